// File: doc/BRIEF.md
# Receive Frame Length Statistics Unit

This block sits beside a receive path and keeps the length statistics for incoming frames. For each frame the receive logic raises a one-cycle report strobe along with two lengths: the frame length without the four-byte frame check sequence (FCS), and the length with it. The report also carries two control bits. The long-frame enable raises the size limit, and the keep-bad-frames override turns the size check off.

From each report the unit decides whether the frame is too long. A frame that is too long is flagged for drop and counted in an oversize counter. A frame that is accepted is sorted into one of six length bins, counted in a total-frames counter, and its byte count is added to a wide octet counter. The octet counter always includes the four FCS bytes. Some registers are duplicates of others under a second name: good frames repeats total frames, and the good-octet pair repeats the octet pair. A host reads every register through a simple registered read port. The octet counter is read as two halves, and the upper half is frozen when the lower half is read.

Top module: `rx_len_stats`

## Requirements
- R1: With the long-frame enable low and the override low, a frame whose length without FCS is above 1522 is dropped, and a length of 1522 is accepted.
- R2: With the override low, a frame whose length without FCS is above 16384 is dropped whatever the long-frame enable says, and a length of 16384 with the enable high is accepted.
- R3: With the keep-bad-frames override high, no frame is dropped, whatever its length.
- R4: The drop flag and its valid bit are registered and appear on the clock edge that samples the report strobe. Each dropped frame adds one to the oversize counter at read address 0.
- R5: A dropped frame leaves the bins, the frame totals and the octet totals unchanged.
- R6: An accepted frame adds one to exactly one bin, chosen by its length with FCS. The bins are 64 (address 1), 65–127 (address 2), 128–255 (address 3), 256–511 (address 4), 512–1023 (address 5), and 1024 or more (address 6).
- R7: An accepted frame shorter than 64 bytes with FCS changes no bin, but it is still counted in the totals.
- R8: Each accepted frame adds one to the total-frames register at address 7. The good-frames register at address 8 always reads the same value.
- R9: Each accepted frame adds its length without FCS plus 4 to the octet counter. The counter is two read words wide: low half at address 9, high half at address 10. The good-octet pair at addresses 11 and 12 reads the same value.
- R10: A read of either low octet half (address 9 or 11) freezes the high half at that moment. A later read of address 10 or 12 returns the frozen value.
- R11: Every counter stops at its all-ones value and does not wrap.
- R12: After reset every register reads zero. Read data appears on the clock edge that samples the read enable, and addresses not listed return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rptValid | input | 1 | One-cycle frame report strobe |
| lenData | input | LEN_W | Frame length without FCS |
| lenWithFcs | input | LEN_W | Frame length including FCS |
| longPktEn | input | 1 | Long-frame enable (raises the size limit to 16384) |
| storeBadPkt | input | 1 | Keep-bad-frames override (turns the size check off) |
| dropFlag | output | 1 | Frame was too long and is to be dropped |
| dropValid | output | 1 | dropFlag holds a decision for a report |
| rdEn | input | 1 | Register read strobe |
| rdAddr | input | 4 | Register read address |
| rdData | output | RD_W | Registered read data |

## Verification
Some properties are checked by assertions on every cycle. The valid bit must trail the report strobe by one edge. The override must suppress every drop, and lengths above the limits must be dropped. An accepted frame must raise the frame total by exactly one, a dropped frame must raise only the oversize count, and the octet total must never go down.

Other behaviours can only be shown by the bench's scenarios. These are:
- the exact bin chosen at each boundary length;
- frames shorter than 64 bytes falling into no bin;
- the mirrored registers;
- the frozen high octet half across a carry into it;
- saturation of the narrow counters.

The bench shows these by running frame sequences and reading the registers back through the read port.

// File: rtl/rx_len_stats_pkg.sv
package rx_len_stats_pkg;
  localparam int NUM_BINS = 6;

  typedef struct packed {
    logic                ovInc;
    logic                totInc;
    logic [NUM_BINS-1:0] binInc;
  } statStrobe_t;

  localparam logic [3:0] ADDR_OV     = 4'd0;
  localparam logic [3:0] ADDR_BIN0   = 4'd1;
  localparam logic [3:0] ADDR_TOT    = 4'd7;
  localparam logic [3:0] ADDR_GOOD   = 4'd8;
  localparam logic [3:0] ADDR_OCT_LO = 4'd9;
  localparam logic [3:0] ADDR_OCT_HI = 4'd10;
  localparam logic [3:0] ADDR_GOC_LO = 4'd11;
  localparam logic [3:0] ADDR_GOC_HI = 4'd12;
endpackage

// File: rtl/rx_len_stats_ctrl.sv
module rx_len_stats_ctrl
  import rx_len_stats_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int STD_MAX   = 1522,
  parameter int JUMBO_MAX = 16384
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rptValid,
  input  logic [LEN_W-1:0] lenData,
  input  logic [LEN_W-1:0] lenWithFcs,
  input  logic             longPktEn,
  input  logic             storeBadPkt,
  output statStrobe_t      strobe,
  output logic             dropFlag,
  output logic             dropValid
);
  localparam logic [LEN_W-1:0] STD_LIM   = LEN_W'(STD_MAX);
  localparam logic [LEN_W-1:0] JUMBO_LIM = LEN_W'(JUMBO_MAX);

  logic tooLong;
  logic [NUM_BINS-1:0] binSel;

  always_comb begin
    tooLong = !storeBadPkt &&
              ((lenData > JUMBO_LIM) || (!longPktEn && (lenData > STD_LIM)));
  end

  // Length bins on the FCS-inclusive length; below 64 selects none.
  always_comb begin
    binSel = '0;
    if (lenWithFcs >= LEN_W'(1024))      binSel[5] = 1'b1;
    else if (lenWithFcs >= LEN_W'(512))  binSel[4] = 1'b1;
    else if (lenWithFcs >= LEN_W'(256))  binSel[3] = 1'b1;
    else if (lenWithFcs >= LEN_W'(128))  binSel[2] = 1'b1;
    else if (lenWithFcs >= LEN_W'(65))   binSel[1] = 1'b1;
    else if (lenWithFcs == LEN_W'(64))   binSel[0] = 1'b1;
  end

  always_comb begin
    strobe.ovInc  = rptValid && tooLong;
    strobe.totInc = rptValid && !tooLong;
    strobe.binInc = (rptValid && !tooLong) ? binSel : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dropFlag  <= 1'b0;
      dropValid <= 1'b0;
    end else begin
      dropValid <= rptValid;
      dropFlag  <= rptValid && tooLong;
    end
  end
endmodule

// File: rtl/rx_len_stats_dp.sv
module rx_len_stats_dp
  import rx_len_stats_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CNT_W = 32,
  parameter int RD_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  statStrobe_t       strobe,
  input  logic [LEN_W-1:0]  lenData,
  input  logic              rdEn,
  input  logic [3:0]        rdAddr,
  output logic [RD_W-1:0]   rdData,
  output logic [CNT_W-1:0]  ovTotal,
  output logic [CNT_W-1:0]  pktTotal,
  output logic [2*RD_W-1:0] octTotal
);
  localparam int OCT_W = 2 * RD_W;

  logic [CNT_W-1:0] binCnt [NUM_BINS];
  logic [OCT_W:0]   octSum;
  logic [RD_W-1:0]  hiLatch;
  logic [RD_W-1:0]  rdMux;

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
    always_ff @(posedge clk) begin
      if (!rstN) binCnt[b] <= '0;
      else if (strobe.binInc[b] && binCnt[b] != '1) binCnt[b] <= binCnt[b] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovTotal  <= '0;
      pktTotal <= '0;
    end else begin
      if (strobe.ovInc && ovTotal != '1)   ovTotal  <= ovTotal + 1'b1;
      if (strobe.totInc && pktTotal != '1) pktTotal <= pktTotal + 1'b1;
    end
  end

  always_comb begin
    octSum = {1'b0, octTotal} + {{(OCT_W+1-LEN_W){1'b0}}, lenData} + (OCT_W+1)'(4);
  end

  always_ff @(posedge clk) begin
    if (!rstN) octTotal <= '0;
    else if (strobe.totInc) octTotal <= octSum[OCT_W] ? '1 : octSum[OCT_W-1:0];
  end

  always_comb begin
    rdMux = '0;
    case (rdAddr)
      ADDR_OV:                 rdMux = RD_W'(ovTotal);
      ADDR_TOT, ADDR_GOOD:     rdMux = RD_W'(pktTotal);
      ADDR_OCT_LO, ADDR_GOC_LO: rdMux = octTotal[RD_W-1:0];
      ADDR_OCT_HI, ADDR_GOC_HI: rdMux = hiLatch;
      default: begin
        for (int b = 0; b < NUM_BINS; b++)
          if (rdAddr == ADDR_BIN0 + 4'(b)) rdMux = RD_W'(binCnt[b]);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      hiLatch <= '0;
    end else if (rdEn) begin
      rdData <= rdMux;
      if (rdAddr == ADDR_OCT_LO || rdAddr == ADDR_GOC_LO) hiLatch <= octTotal[OCT_W-1:RD_W];
    end
  end
endmodule

// File: rtl/rx_len_stats.sv
module rx_len_stats
  import rx_len_stats_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CNT_W = 32,
  parameter int RD_W  = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rptValid,
  input  logic [LEN_W-1:0] lenData,
  input  logic [LEN_W-1:0] lenWithFcs,
  input  logic             longPktEn,
  input  logic             storeBadPkt,
  output logic             dropFlag,
  output logic             dropValid,
  input  logic             rdEn,
  input  logic [3:0]       rdAddr,
  output logic [RD_W-1:0]  rdData
);
  statStrobe_t        strobe;
  logic [CNT_W-1:0]   ovTotal;
  logic [CNT_W-1:0]   pktTotal;
  logic [2*RD_W-1:0]  octTotal;

  rx_len_stats_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rptValid(rptValid), .lenData(lenData),
    .lenWithFcs(lenWithFcs), .longPktEn(longPktEn), .storeBadPkt(storeBadPkt),
    .strobe(strobe), .dropFlag(dropFlag), .dropValid(dropValid)
  );

  rx_len_stats_dp #(.LEN_W(LEN_W), .CNT_W(CNT_W), .RD_W(RD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lenData(lenData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .ovTotal(ovTotal), .pktTotal(pktTotal), .octTotal(octTotal)
  );
endmodule

// File: rtl/rx_len_stats_chk.sv
module rx_len_stats_chk #(
  parameter int LEN_W = 16,
  parameter int CNT_W = 32,
  parameter int RD_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              rptValid,
  input logic [LEN_W-1:0]  lenData,
  input logic              longPktEn,
  input logic              storeBadPkt,
  input logic              dropFlag,
  input logic              dropValid,
  input logic [CNT_W-1:0]  ovTotal,
  input logic [CNT_W-1:0]  pktTotal,
  input logic [2*RD_W-1:0] octTotal
);
  assert_std_limit_R1: assert property (@(posedge clk) disable iff (!rstN)
    rptValid && !storeBadPkt && !longPktEn && lenData > LEN_W'(1522) |=> dropFlag);

  assert_jumbo_limit_R2: assert property (@(posedge clk) disable iff (!rstN)
    rptValid && !storeBadPkt && lenData > LEN_W'(16384) |=> dropFlag);

  assert_override_keeps_R3: assert property (@(posedge clk) disable iff (!rstN)
    rptValid && storeBadPkt |=> !dropFlag);

  assert_drop_timing_R4: assert property (@(posedge clk) disable iff (!rstN)
    rptValid |=> dropValid);

  assert_drop_counts_R4: assert property (@(posedge clk) disable iff (!rstN)
    dropValid && dropFlag && $past(ovTotal) != '1 |-> ovTotal == $past(ovTotal) + 1'b1);

  assert_drop_no_totals_R5: assert property (@(posedge clk) disable iff (!rstN)
    dropValid && dropFlag |-> pktTotal == $past(pktTotal) && octTotal == $past(octTotal));

  assert_accept_counts_R8: assert property (@(posedge clk) disable iff (!rstN)
    dropValid && !dropFlag && $past(pktTotal) != '1 |-> pktTotal == $past(pktTotal) + 1'b1);

  assert_no_wrap_R11: assert property (@(posedge clk) disable iff (!rstN)
    octTotal >= $past(octTotal) && pktTotal >= $past(pktTotal) && ovTotal >= $past(ovTotal));
endmodule

bind rx_len_stats rx_len_stats_chk #(.LEN_W(LEN_W), .CNT_W(CNT_W), .RD_W(RD_W)) u_chk (
  .clk(clk), .rstN(rstN), .rptValid(rptValid), .lenData(lenData),
  .longPktEn(longPktEn), .storeBadPkt(storeBadPkt), .dropFlag(dropFlag),
  .dropValid(dropValid), .ovTotal(ovTotal), .pktTotal(pktTotal), .octTotal(octTotal)
);

// File: tb/rx_len_stats_tb.sv
module rx_len_stats_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 16;
  localparam int CNT_W = 8;
  localparam int RD_W  = 16;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0, rstN = 1'b0;
  logic rptValid = 1'b0, longPktEn = 1'b0, storeBadPkt = 1'b0, rdEn = 1'b0;
  logic [LEN_W-1:0] lenData = '0, lenWithFcs = '0;
  logic [3:0] rdAddr = '0;
  logic dropFlag, dropValid;
  logic [RD_W-1:0] rdData;

  int checks = 0, failures = 0;
  bit expDropQ[$];
  string expTagQ[$];
  int mOv = 0, mTot = 0;
  int mBin[6];
  longint mOct = 0;

  rx_len_stats #(.LEN_W(LEN_W), .CNT_W(CNT_W), .RD_W(RD_W)) u_dut (
    .clk(clk), .rstN(rstN), .rptValid(rptValid), .lenData(lenData),
    .lenWithFcs(lenWithFcs), .longPktEn(longPktEn), .storeBadPkt(storeBadPkt),
    .dropFlag(dropFlag), .dropValid(dropValid), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sat(int v);
    return (v >= CMAX) ? CMAX : v + 1;
  endfunction

  task automatic sendFrame(int dl, bit lpe, bit sbp, string tag);
    int fl = dl + 4;
    bit drop = !sbp && (dl > 16384 || (!lpe && dl > 1522));
    expDropQ.push_back(drop);
    expTagQ.push_back(tag);
    if (drop) mOv = sat(mOv);
    else begin
      mTot = sat(mTot);
      mOct += dl + 4;
      if (fl >= 1024) mBin[5] = sat(mBin[5]);
      else if (fl >= 512) mBin[4] = sat(mBin[4]);
      else if (fl >= 256) mBin[3] = sat(mBin[3]);
      else if (fl >= 128) mBin[2] = sat(mBin[2]);
      else if (fl >= 65) mBin[1] = sat(mBin[1]);
      else if (fl == 64) mBin[0] = sat(mBin[0]);
    end
    @(negedge clk);
    rptValid = 1'b1; lenData = LEN_W'(dl); lenWithFcs = LEN_W'(fl);
    longPktEn = lpe; storeBadPkt = sbp;
    @(negedge clk);
    rptValid = 1'b0;
  endtask

  task automatic readReg(int addr, longint exp, string tag);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = 4'(addr);
    @(negedge clk);
    rdEn = 1'b0;
    check(tag, rdData, exp);
  endtask

  task automatic checkAll(string tag);
    readReg(0, mOv, {tag, " R4 oversize"});
    for (int b = 0; b < 6; b++) readReg(1 + b, mBin[b], {tag, " R6 bin"});
    readReg(7, mTot, {tag, " R8 total"});
    readReg(8, mTot, {tag, " R8 good"});
    readReg(9, mOct & 16'hFFFF, {tag, " R9 octLo"});
    readReg(10, (mOct >> 16) & 16'hFFFF, {tag, " R9 octHi"});
    readReg(11, mOct & 16'hFFFF, {tag, " R9 goodLo"});
    readReg(12, (mOct >> 16) & 16'hFFFF, {tag, " R9 goodHi"});
  endtask

  // Monitor: pops expected drop decisions as the design reports them.
  always @(negedge clk) begin
    if (rstN && dropValid) begin
      if (expDropQ.size() == 0) check("R4 unexpected dropValid", 1, 0);
      else begin
        automatic bit e = expDropQ.pop_front();
        automatic string t = expTagQ.pop_front();
        check(t, dropFlag, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    longint hiSnap;
    for (int b = 0; b < 6; b++) mBin[b] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkAll("R12 reset");
    readReg(15, 0, "R12 unmapped");

    // Bin boundaries (R6) and short frame (R7)
    sendFrame(60, 0, 0, "R6 len64");
    sendFrame(59, 0, 0, "R7 len63");
    sendFrame(61, 0, 0, "R6 len65");
    sendFrame(123, 0, 0, "R6 len127");
    sendFrame(124, 0, 0, "R6 len128");
    sendFrame(251, 0, 0, "R6 len255");
    sendFrame(252, 0, 0, "R6 len256");
    sendFrame(507, 0, 0, "R6 len511");
    sendFrame(508, 0, 0, "R6 len512");
    sendFrame(1019, 0, 0, "R6 len1023");
    sendFrame(1020, 0, 0, "R6 len1024");
    sendFrame(10, 0, 0, "R7 tiny");
    checkAll("R6 R7 bins");

    // Size limits (R1 R2 R3) and drop effects (R5)
    sendFrame(1522, 0, 0, "R1 at limit");
    sendFrame(1523, 0, 0, "R1 over limit");
    sendFrame(1523, 1, 0, "R1 long enabled");
    sendFrame(16384, 1, 0, "R2 at limit");
    sendFrame(16385, 1, 0, "R2 over limit");
    sendFrame(20000, 0, 0, "R2 over no lpe");
    sendFrame(20000, 0, 1, "R3 override");
    sendFrame(3000, 0, 1, "R3 override std");
    checkAll("R1 R2 R3 R5 totals");

    // High-half freeze (R10)
    readReg(9, mOct & 16'hFFFF, "R10 lo read");
    hiSnap = (mOct >> 16) & 16'hFFFF;
    sendFrame(16000, 1, 0, "R10 grow");
    sendFrame(16000, 1, 0, "R10 grow");
    sendFrame(16000, 1, 0, "R10 grow");
    readReg(10, hiSnap, "R10 frozen hi");
    readReg(11, mOct & 16'hFFFF, "R10 lo reread");
    readReg(12, (mOct >> 16) & 16'hFFFF, "R10 fresh hi");

    // Saturation (R11)
    for (int i = 0; i < 260; i++) sendFrame(60, 0, 0, "R11 fill");
    for (int i = 0; i < 260; i++) sendFrame(2000, 0, 0, "R11 ov fill");
    checkAll("R11 saturated");
    check("R11 model bin sat", mBin[0], CMAX);

    repeat (3) @(negedge clk);
    check("R4 queue drained", expDropQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule